// File: doc/BRIEF.md
# Microcode Sequencer with Opcode Dispatch

This block is the control store and next-address unit of a microprogrammed processor. A 512-word store of 32-bit microinstructions is supplied as a parameter. Each microinstruction is held in a register for two clock cycles, called phase 0 and phase 1. At the end of phase 1 the sequencer picks the next microaddress and loads that word.

The next microaddress depends on two 3-bit control groups and an 8-bit target field inside the word. The groups provide subroutine call, conditional call, return, end-of-instruction, halt and opcode decode. Decode latches the data input as the opcode and jumps into the upper half of the store. That half holds one call word per opcode, so the upper half acts as the instruction decoder.

The block also turns the word into single-phase strobes for the datapath and bus logic around it. These cover IO, read, write, interrupt enable and disable, clear of the T1 operand latch, aux-carry control, and the loads of the address and low-address registers.

Top module: `useq_dispatch`

## Requirements
- R1: While rst_n is low, uaddr_o is 0, phase_o is 0 and ir_o is 0. After release, execution starts at word 0.
- R2: Every microinstruction lasts exactly two cycles, phase 0 followed by phase 1. uaddr_o and uword_o change only on the clock edge that ends phase 1, and uword_o always equals store word uaddr_o.
- R3: Group 1 is bits 31:29 and group 2 is bits 28:26. If no rule below applies, the next microaddress is the current one plus 1, modulo 512.
- R4: When group 1 is neither 001 nor 111 and group 2 is 001 (end), the next microaddress is END_ADDR (default 3).
- R5: When group 1 is 111 (halt), the next microaddress is HALT_ADDR (default 7), whatever group 2 holds, and the saved return address does not change.
- R6: When group 1 is neither 001 nor 111 and group 2 is 010 (call), the next microaddress is the 8-bit target {bits 11:10, bits 5:0}, zero-extended. The current microaddress plus 1 is saved as the single return address.
- R7: When group 1 is neither 001 nor 111 and group 2 is 011 (return), the next microaddress is the saved return address.
- R8: When group 1 is neither 001 nor 111 and group 2 is 100 (conditional call), the block samples cond at the end of phase 1. If cond is 1, it behaves as in R6. If cond is 0, it goes to the current address plus 1 and leaves the return address unchanged.
- R9: When group 1 is 001 (decode), ir_o loads data_in at the end of phase 1, and the next microaddress is 256 + data_in, whatever group 2 holds.
- R10: The following strobes are active only in phase 0:
  - io_o when group 1 is 100
  - ie_clr_o when group 1 is 010
  - ie_set_o when group 1 is 011
  - clr_t1_o when group 1 is 110
  - set_aux_o when group 2 is 111
  - addr_load_o when bit 25 is set
  - al_load_o when bit 24 is set
- R11: rd_o (group 2 = 101) and wr_o (group 2 = 110) are active only in phase 1.
- R12: use_aux_o is active in both phases when group 1 is 101. Bits of the word outside groups 1 and 2, bits 25:24 and the target field do not affect sequencing or strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 8 | Opcode bus, sampled on decode |
| cond | input | 1 | Condition for the conditional call |
| uaddr_o | output | 9 | Current microaddress |
| uword_o | output | 32 | Current microinstruction |
| phase_o | output | 1 | 0 = first cycle, 1 = second cycle |
| ir_o | output | 8 | Latched opcode |
| io_o | output | 1 | IO strobe (phase 0) |
| rd_o | output | 1 | Read strobe (phase 1) |
| wr_o | output | 1 | Write strobe (phase 1) |
| ie_set_o | output | 1 | Enable interrupts (phase 0) |
| ie_clr_o | output | 1 | Disable interrupts (phase 0) |
| clr_t1_o | output | 1 | Clear T1 (phase 0) |
| use_aux_o | output | 1 | Use aux carry (both phases) |
| set_aux_o | output | 1 | Set aux carry (phase 0) |
| addr_load_o | output | 1 | Load address register, memory cycle valid (phase 0) |
| al_load_o | output | 1 | Load low-address register (phase 0) |

## Verification
The bench builds the block with the default END_ADDR and HALT_ADDR. It overrides the store with a program computed in the bench:
- The upper half holds a call word per opcode, with targets that cover every value of the split target field's upper bits.
- Thirty short routines mix every group-1 and group-2 code with both load bits.
- One shared subroutine ends in a return.

The bench drives the decode input with an opcode counter, so every one of the 256 dispatch entries is taken. The condition input is toggled so that conditional calls are both taken and skipped.

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
  parameter int WW        = 32,
  parameter int DEPTH     = 512,
  parameter int END_ADDR  = 3,
  parameter int HALT_ADDR = 7,
  parameter logic [DEPTH*WW-1:0] UCODE = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               data_in,
  input  logic                     cond,
  output logic [$clog2(DEPTH)-1:0] uaddr_o,
  output logic [WW-1:0]            uword_o,
  output logic                     phase_o,
  output logic [7:0]               ir_o,
  output logic                     io_o,
  output logic                     rd_o,
  output logic                     wr_o,
  output logic                     ie_set_o,
  output logic                     ie_clr_o,
  output logic                     clr_t1_o,
  output logic                     use_aux_o,
  output logic                     set_aux_o,
  output logic                     addr_load_o,
  output logic                     al_load_o
);
  localparam int AW = $clog2(DEPTH);

  localparam logic [2:0] G1_DEC  = 3'b001, G1_DI  = 3'b010, G1_EI  = 3'b011,
                         G1_IO   = 3'b100, G1_AUX = 3'b101, G1_CT1 = 3'b110,
                         G1_HALT = 3'b111;
  localparam logic [2:0] G2_END  = 3'b001, G2_CALL = 3'b010, G2_RET = 3'b011,
                         G2_TCALL = 3'b100, G2_RD = 3'b101, G2_WR  = 3'b110,
                         G2_SAUX = 3'b111;

  function automatic logic [WW-1:0] rom_at(input logic [AW-1:0] a);
    return UCODE[int'(a)*WW +: WW];
  endfunction

  logic [2:0]    g1, g2;
  logic [7:0]    tgt;
  logic [AW-1:0] ret_q, nxt, inc;
  logic          call;

  assign g1  = uword_o[31:29];
  assign g2  = uword_o[28:26];
  assign tgt = {uword_o[11:10], uword_o[5:0]};
  assign inc = uaddr_o + 1'b1;

  always_comb begin
    nxt  = inc;
    call = 1'b0;
    if (g1 == G1_HALT)
      nxt = AW'(HALT_ADDR);
    else if (g1 == G1_DEC)
      nxt = {1'b1, data_in};
    else begin
      case (g2)
        G2_END:   nxt = AW'(END_ADDR);
        G2_CALL:  begin nxt = AW'(tgt); call = 1'b1; end
        G2_RET:   nxt = ret_q;
        G2_TCALL: if (cond) begin nxt = AW'(tgt); call = 1'b1; end
        default:  nxt = inc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o <= 1'b0;
      uaddr_o <= '0;
      uword_o <= rom_at('0);
      ret_q   <= '0;
      ir_o    <= '0;
    end else begin
      phase_o <= ~phase_o;
      if (phase_o) begin
        uaddr_o <= nxt;
        uword_o <= rom_at(nxt);
        if (call) ret_q <= inc;
        if (g1 == G1_DEC) ir_o <= data_in;
      end
    end
  end

  assign io_o        = ~phase_o & (g1 == G1_IO);
  assign ie_clr_o    = ~phase_o & (g1 == G1_DI);
  assign ie_set_o    = ~phase_o & (g1 == G1_EI);
  assign clr_t1_o    = ~phase_o & (g1 == G1_CT1);
  assign set_aux_o   = ~phase_o & (g2 == G2_SAUX);
  assign addr_load_o = ~phase_o & uword_o[25];
  assign al_load_o   = ~phase_o & uword_o[24];
  assign use_aux_o   = (g1 == G1_AUX);
  assign rd_o        = phase_o & (g2 == G2_RD);
  assign wr_o        = phase_o & (g2 == G2_WR);

  logic plain;
  assign plain = (g1 != G1_HALT) && (g1 != G1_DEC);

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_o |=> $stable(uaddr_o) && $stable(uword_o));
  a_r4_end: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o && plain && g2 == G2_END |=> uaddr_o == AW'(END_ADDR));
  a_r5_halt: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o && g1 == G1_HALT |=> uaddr_o == AW'(HALT_ADDR) && $stable(ret_q));
  a_r7_return: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o && plain && g2 == G2_RET |=> uaddr_o == $past(ret_q));
  a_r9_decode: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o && g1 == G1_DEC |=> uaddr_o == {1'b1, $past(data_in)} && ir_o == $past(data_in));
  a_r10_first_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (io_o || addr_load_o || al_load_o || ie_set_o || ie_clr_o) |-> !phase_o);
  a_r11_second_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o || wr_o) |-> phase_o);
endmodule

// File: tb/test_useq_dispatch.sv
module test_useq_dispatch;
  function automatic logic [31:0] mk_word(input int i);
    logic [31:0] w;
    logic [7:0]  t;
    int b, j, g1, g2;
    w = '0;
    if (i >= 256) begin
      t = 8'(8 * (1 + ((i - 256) % 30)) + ((i - 256) % 3));
      w = {3'd0, 3'b010, 2'b00, 12'hA5C, t[7:6], 4'h9, t[5:0]};
    end else if (i < 8) begin
      case (i)
        0: w = {3'd0, 3'd0, 2'b10, 24'h0};
        1: w = {3'b100, 3'd0, 2'b01, 24'h0};
        2: w = {3'd0, 3'b001, 26'h0};
        3: w = {3'b001, 3'b010, 2'b00, 12'hFFF, 2'b11, 4'h0, 6'h3F};
        7: w = {3'd0, 3'b001, 26'h0};
        default: w = '0;
      endcase
    end else if (i < 16) begin
      if (i == 8)      w = {3'd0, 3'b101, 26'h0};
      else if (i == 9) w = {3'd0, 3'b011, 26'h0};
      else             w = {3'd0, 3'b001, 26'h0};
    end else begin
      b = i / 8 - 1;
      j = i % 8;
      if (j == 7) w = {3'd0, 3'b001, 26'h0};
      else begin
        g1 = (b * 5 + j * 3) % 8; if (g1 == 1) g1 = 0;
        g2 = (b * 3 + j * 7) % 8; if (g2 == 3) g2 = 0;
        w = {3'(g1), 3'(g2), 1'((b + j) & 1), 1'(((b >> 1) + j) & 1),
             12'(b * j + 1), 2'b00, 4'(b), 6'd8};
      end
    end
    return w;
  endfunction

  function automatic logic [16383:0] build_prog();
    logic [16383:0] p;
    p = '0;
    for (int i = 0; i < 512; i++) p[i*32 +: 32] = mk_word(i);
    return p;
  endfunction

  localparam logic [16383:0] PROG = build_prog();

  logic clk = 0, rst_n = 0, cond = 0;
  logic [7:0] data_in = 0;
  logic [8:0] uaddr_o;
  logic [31:0] uword_o;
  logic phase_o;
  logic [7:0] ir_o;
  logic io_o, rd_o, wr_o, ie_set_o, ie_clr_o, clr_t1_o, use_aux_o, set_aux_o, addr_load_o, al_load_o;

  useq_dispatch #(.UCODE(PROG)) i_useq_dispatch (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .cond(cond),
    .uaddr_o(uaddr_o), .uword_o(uword_o), .phase_o(phase_o), .ir_o(ir_o),
    .io_o(io_o), .rd_o(rd_o), .wr_o(wr_o), .ie_set_o(ie_set_o), .ie_clr_o(ie_clr_o),
    .clr_t1_o(clr_t1_o), .use_aux_o(use_aux_o), .set_aux_o(set_aux_o),
    .addr_load_o(addr_load_o), .al_load_o(al_load_o));

  always #4ns clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] strobes(input logic [31:0] w, input bit ph);
    logic [2:0] a, c;
    a = w[31:29]; c = w[28:26];
    return {!ph && a == 3'b100, ph && c == 3'b101, ph && c == 3'b110,
            !ph && a == 3'b011, !ph && a == 3'b010, !ph && a == 3'b110,
            a == 3'b101, !ph && c == 3'b111, !ph && w[25], !ph && w[24]};
  endfunction

  function automatic logic [9:0] got_strobes();
    return {io_o, rd_o, wr_o, ie_set_o, ie_clr_o, clr_t1_o, use_aux_o, set_aux_o, addr_load_o, al_load_o};
  endfunction

  initial begin
    logic [8:0] ea, eret, nx;
    logic [7:0] eir, opc, tg;
    logic [31:0] w;
    logic [2:0] a, c;
    int ndec, step, n_tk, n_nt, n_halt, n_ret;
    bit seen [256];
    int miss;
    ea = 0; eret = 0; eir = 0; opc = 0; ndec = 0; step = 0;
    n_tk = 0; n_nt = 0; n_halt = 0; n_ret = 0;
    for (int k = 0; k < 256; k++) seen[k] = 0;
    repeat (3) @(negedge clk);
    chk(uaddr_o == 0, "R1", "reset uaddr", uaddr_o, 0);
    chk(phase_o == 0, "R1", "reset phase", phase_o, 0);
    chk(ir_o == 0, "R1", "reset ir", ir_o, 0);
    rst_n = 1;
    while (ndec < 300 && step < 30000) begin
      w = mk_word(int'(ea));
      data_in = opc;
      cond = step[0] ^ step[2];
      chk(phase_o == 0, "R2", "phase0", phase_o, 0);
      chk(uaddr_o == ea, "R3", "uaddr", uaddr_o, ea);
      chk(uword_o == w, "R2", "uword", uword_o, w);
      chk(ir_o == eir, "R9", "ir", ir_o, eir);
      chk(got_strobes() == strobes(w, 0), "R10", "phase0 strobes", got_strobes(), strobes(w, 0));
      @(negedge clk);
      chk(phase_o == 1, "R2", "phase1", phase_o, 1);
      chk(uaddr_o == ea, "R2", "uaddr hold", uaddr_o, ea);
      chk(got_strobes() == strobes(w, 1), "R11", "phase1 strobes", got_strobes(), strobes(w, 1));
      a = w[31:29]; c = w[28:26]; tg = {w[11:10], w[5:0]};
      nx = ea + 1'b1;
      if (a == 3'b111) begin nx = 9'd7; n_halt++; end
      else if (a == 3'b001) begin
        nx = {1'b1, opc}; eir = opc; seen[opc] = 1; opc++; ndec++;
      end else if (c == 3'b001) nx = 9'd3;
      else if (c == 3'b010) begin nx = {1'b0, tg}; eret = ea + 1'b1; end
      else if (c == 3'b011) begin nx = eret; n_ret++; end
      else if (c == 3'b100) begin
        if (cond) begin nx = {1'b0, tg}; eret = ea + 1'b1; n_tk++; end
        else n_nt++;
      end
      ea = nx;
      step++;
      @(negedge clk);
    end
    miss = 0;
    for (int k = 0; k < 256; k++) if (!seen[k]) miss++;
    chk(miss == 0, "R9", "opcodes not dispatched", miss, 0);
    chk(n_tk > 0 && n_nt > 0, "R8", "cond call taken/skipped coverage", n_tk, n_nt);
    chk(n_halt > 0, "R5", "halt coverage", n_halt, 1);
    chk(n_ret > 0, "R7", "return coverage", n_ret, 1);
    chk(ndec >= 300, "R6", "dispatch progress", ndec, 300);
    rst_n = 0;
    @(negedge clk);
    chk(uaddr_o == 0 && phase_o == 0 && ir_o == 0, "R1", "mid-run reset", uaddr_o, 0);
    chk(uword_o == mk_word(0), "R12", "reset word", uword_o, mk_word(0));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8ns * 190000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule